// File: doc/BRIEF.md
# Two-Wire Bus Addressed Slave Engine

This block is the slave side of a two-wire, open-drain serial bus of the I2C kind. It runs on a system clock that is much faster than the bus clock. It brings the SCL and SDA pins into that clock domain and watches them for bus conditions. A START, or a repeated START, sends it to collect an address byte. That byte holds a 7-bit calling address and a direction bit, and the block compares the address with a value supplied on a port. When the address matches, the block acknowledges and then carries whole bytes in the direction the master asked for.

Received bytes leave on a byte port as a one-cycle valid strobe. Bytes to be sent are requested by a one-cycle strobe, and the surrounding logic presents them on a byte input. The block never drives SDA high. It only asserts a pull-down enable, which the pad turns into an open-drain driver.

The controller has seven states:
- IDLE: released, waiting for START.
- ADDR: shifting in the address byte.
- ACK_OUT: the slave holds SDA low for the ninth clock.
- RX: shifting in a data byte.
- TX: driving out a data byte.
- ACK_IN: sampling the master's acknowledge.
- TX_LOAD: the master has acknowledged, waiting to load the next byte.

The transitions are:
- START from any state goes to ADDR.
- STOP from any state goes to IDLE.
- ADDR goes to ACK_OUT on the falling edge after the eighth bit when the address matches, and to IDLE at the eighth rising edge when it does not.
- ACK_OUT goes to RX (write) or TX (read) on the falling edge that ends the ninth clock.
- RX goes to ACK_OUT after eight bits.
- TX goes to ACK_IN after eight bits.
- ACK_IN goes to TX_LOAD on an acknowledge and to IDLE on a missing acknowledge.
- TX_LOAD goes to TX on the next falling edge.

Top module: `twb_slave`

## Requirements
- R1: While reset is asserted, and right after it, `sda_oe`, `rx_valid` and `tx_req` are 0.
- R2: The first byte after a START carries the address in bits [7:1] and the direction in bit 0, where 1 means the master reads. When bits [7:1] equal `own_addr`, the slave pulls SDA low for the whole high phase of the ninth clock.
- R3: When the address does not match, SDA stays released at the ninth clock and for every later bit. No `rx_valid` or `tx_req` appears until the next START.
- R4: In write mode, each data byte is taken MSB first. It appears on `rx_data` with a single-cycle `rx_valid` pulse, and the slave acknowledges it on the ninth clock.
- R5: In read mode, `tx_req` pulses once for every byte the slave will need. `tx_data` is captured on the SCL falling edge that ends the acknowledge clock. Bits leave MSB first, with a low bit shown as SDA pulled low.
- R6: In read mode, an acknowledge from the master (SDA low at the ninth clock) leads to the next byte. A missing acknowledge makes the slave release SDA, request no further byte and ignore clocks until START or STOP.
- R7: A START seen while a transfer is in progress, even in the middle of a byte, abandons that transfer. The next byte is treated as a fresh address.
- R8: A STOP, even one directly after the slave's acknowledge, releases SDA and returns to idle. Bytes clocked after it without a START draw no acknowledge and no `rx_valid`.
- R9: `sda_oe` changes only while SCL is low. It never changes during an SCL high phase, except to release on a START or STOP.
- R10: START is a falling SDA while SCL is high, and STOP is a rising SDA while SCL is high. Both are judged on the synchronized lines, so SDA changes while SCL is low are data, not conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 7 | Address this slave answers to |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level (the wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rx_data | output | 8 | Last byte written by the master |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a new byte |
| tx_data | input | 8 | Byte to send, captured at the falling SCL edge after the acknowledge |
| tx_req | output | 1 | One-cycle strobe: present the next byte on `tx_data` |

## Verification
Two situations are hard to reach from the pins. One is a repeated START in the middle of a byte: the master must stop after a few data bits and build a START with the bus in a half-shifted state. The other is the master's missing acknowledge on a read, after which the slave must stay silent. The bench models the bus as the AND of a behavioural master and the slave's pull-down, and drives whole bus sequences through tasks. It cuts a write off after three bits with a repeated START, turns a read into a different slave request, and keeps clocking after a NACK while it watches that every bit reads back high. A per-cycle monitor checks every received byte against a queue of expected bytes and checks that the pull-down never moves during a settled SCL high phase.

// File: rtl/twb_pkg.sv
`timescale 1ns/1ps
package twb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_OUT,
        ST_RX,
        ST_TX,
        ST_ACK_IN,
        ST_TX_LOAD
    } twb_state_e;

endpackage

// File: rtl/twb_cond.sv
`timescale 1ns/1ps
module twb_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prv;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign cur[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prv <= '1;
        else        prv <= cur;
    end

    assign scl_s     = cur[0];
    assign sda_s     = cur[1];
    assign scl_rise  =  cur[0] & ~prv[0];
    assign scl_fall  = ~cur[0] &  prv[0];
    // R10: conditions only while SCL is high on both samples
    assign start_det = cur[0] & prv[0] &  prv[1] & ~cur[1];
    assign stop_det  = cur[0] & prv[0] & ~prv[1] &  cur[1];

    assert_cond_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |-> (scl_s && !scl_rise))
        else $error("condition flagged outside SCL high");

endmodule

// File: rtl/twb_fsm.sv
`timescale 1ns/1ps
module twb_fsm
    import twb_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-1:0] tx_data,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              tx_req
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    twb_state_e        state, state_n;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sh;
    logic              rw;
    logic              addr_hit;

    assign addr_hit = (sh[ADDR_W-1:0] == own_addr);

    // next-state logic
    always_comb begin
        state_n = state;
        if (start_det) begin
            state_n = ST_ADDR;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise && cnt == LAST && !addr_hit) state_n = ST_IDLE;
                    else if (scl_fall && cnt == FULL)         state_n = ST_ACK_OUT;
                end
                ST_ACK_OUT: if (scl_fall) state_n = rw ? ST_TX : ST_RX;
                ST_RX:      if (scl_fall && cnt == FULL) state_n = ST_ACK_OUT;
                ST_TX:      if (scl_fall && cnt == FULL) state_n = ST_ACK_IN;
                ST_ACK_IN:  if (scl_rise) state_n = sda_s ? ST_IDLE : ST_TX_LOAD;
                ST_TX_LOAD: if (scl_fall) state_n = ST_TX;
                default:    state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            sh       <= '0;
            rw       <= 1'b0;
            sda_oe   <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            tx_req   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_req   <= 1'b0;
            if (start_det || stop_det) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR: begin
                        if (scl_rise && cnt != FULL) begin
                            sh  <= {sh[DATA_W-2:0], sda_s};
                            cnt <= cnt + ONE;
                            if (cnt == LAST) begin
                                rw <= sda_s;
                                if (addr_hit && sda_s) tx_req <= 1'b1;
                            end
                        end
                        if (scl_fall && cnt == FULL) sda_oe <= 1'b1;
                    end
                    ST_ACK_OUT: begin
                        if (scl_fall) begin
                            if (rw) begin
                                sh     <= tx_data;
                                sda_oe <= ~tx_data[DATA_W-1];
                                cnt    <= ONE;
                            end else begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                            end
                        end
                    end
                    ST_RX: begin
                        if (scl_rise && cnt != FULL) begin
                            sh  <= {sh[DATA_W-2:0], sda_s};
                            cnt <= cnt + ONE;
                            if (cnt == LAST) begin
                                rx_data  <= {sh[DATA_W-2:0], sda_s};
                                rx_valid <= 1'b1;
                            end
                        end
                        if (scl_fall && cnt == FULL) sda_oe <= 1'b1;
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == FULL) begin
                                sda_oe <= 1'b0;
                            end else begin
                                sda_oe <= ~sh[DATA_W-2];
                                sh     <= sh << 1;
                                cnt    <= cnt + ONE;
                            end
                        end
                    end
                    ST_ACK_IN: begin
                        if (scl_rise && !sda_s) tx_req <= 1'b1;
                    end
                    ST_TX_LOAD: begin
                        if (scl_fall) begin
                            sh     <= tx_data;
                            sda_oe <= ~tx_data[DATA_W-1];
                            cnt    <= ONE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_start_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && cnt == '0 && !sda_oe))
        else $error("START did not return to address phase");

    assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe))
        else $error("STOP did not release the bus");

    assert_sda_quiet_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && !start_det && !stop_det) |=> $stable(sda_oe))
        else $error("SDA drive changed while SCL high");

    assert_rx_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid)
        else $error("rx_valid longer than one cycle");

    assert_tx_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req)
        else $error("tx_req longer than one cycle");

    assert_nack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK_IN && scl_rise && sda_s && !start_det && !stop_det)
            |=> (state == ST_IDLE && !sda_oe && !tx_req))
        else $error("missing master acknowledge not honoured");

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!sda_oe && !rx_valid))
        else $error("idle slave touching the bus");

endmodule

// File: rtl/twb_slave.sv
`timescale 1ns/1ps
module twb_slave #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_req
);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    twb_cond #(.STAGES(SYNC_STAGES)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twb_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_addr  (own_addr),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .tx_data   (tx_data),
        .sda_oe    (sda_oe),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .tx_req    (tx_req)
    );

endmodule

// File: tb/twb_slave_test.sv
`timescale 1ns/1ps
module twb_slave_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [6:0] own_addr = 7'h2A;
    logic [7:0] tx_data = 8'h00;
    logic       sda_oe, rx_valid, tx_req;
    logic [7:0] rx_data;
    logic       sda_line;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    twb_slave uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .own_addr (own_addr),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .sda_oe   (sda_oe),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .tx_data  (tx_data),
        .tx_req   (tx_req)
    );

    int checks = 0;
    int errors = 0;
    int txreq_cnt = 0;
    int hi_run = 0;
    logic prev_oe = 1'b0;
    logic [7:0] exp_rx[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // per-cycle reference comparison
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (exp_rx.size() == 0) begin
                    check(1'b0, "R3", "unexpected rx_valid", int'(rx_data), 0);
                end else begin
                    check(rx_data == exp_rx[0], "R4", "received byte",
                          int'(rx_data), int'(exp_rx[0]));
                    void'(exp_rx.pop_front());
                end
            end
            if (tx_req) txreq_cnt++;
            if (scl_m) hi_run++;
            else       hi_run = 0;
            if (hi_run > 4)
                check(sda_oe == prev_oe, "R9", "drive moved in SCL high",
                      int'(sda_oe), int'(prev_oe));
            prev_oe = sda_oe;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic bus_bit(input bit v, output bit seen);
        sda_m = v;
        tick(5);
        scl_m = 1'b1;
        tick(6);
        seen = sda_line;
        tick(4);
        scl_m = 1'b0;
        tick(5);
    endtask

    task automatic start_c();
        sda_m = 1'b1;
        tick(5);
        scl_m = 1'b1;
        tick(10);
        sda_m = 1'b0;
        tick(10);
        scl_m = 1'b0;
        tick(5);
    endtask

    task automatic stop_c();
        sda_m = 1'b0;
        tick(5);
        scl_m = 1'b1;
        tick(10);
        sda_m = 1'b1;
        tick(10);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack,
                             input bit push, input string req);
        bit s;
        if (push) exp_rx.push_back(b);
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        check(s == !exp_ack, req, "ninth-clock SDA", int'(s), int'(!exp_ack));
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic [7:0] nxt,
                             input bit mack, input string req);
        bit s;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            got[i] = s;
        end
        tx_data = nxt;
        check(got == exp, req, "byte read from slave", int'(got), int'(exp));
        bus_bit(!mack, s);
    endtask

    initial begin
        int t0;
        bit s;
        tick(3);
        // R1: reset state
        check(sda_oe == 1'b0,   "R1", "sda_oe in reset",   int'(sda_oe), 0);
        check(rx_valid == 1'b0, "R1", "rx_valid in reset", int'(rx_valid), 0);
        check(tx_req == 1'b0,   "R1", "tx_req in reset",   int'(tx_req), 0);
        rst_n = 1'b1;
        tick(10);
        check(sda_oe == 1'b0, "R1", "sda_oe after reset", int'(sda_oe), 0);

        // R2/R4/R10: write to own address
        start_c();
        send_byte({7'h2A, 1'b0}, 1'b1, 1'b0, "R2");
        send_byte(8'hA5, 1'b1, 1'b1, "R4");
        send_byte(8'h3C, 1'b1, 1'b1, "R10");
        send_byte(8'hFF, 1'b1, 1'b1, "R4");
        send_byte(8'h00, 1'b1, 1'b1, "R4");
        stop_c();
        tick(6);
        check(sda_oe == 1'b0, "R8", "released after STOP", int'(sda_oe), 0);
        check(exp_rx.size() == 0, "R4", "all bytes delivered", exp_rx.size(), 0);

        // R3: other address, write then read direction
        t0 = txreq_cnt;
        start_c();
        send_byte({7'h15, 1'b0}, 1'b0, 1'b0, "R3");
        send_byte(8'h99, 1'b0, 1'b0, "R3");
        start_c();
        send_byte({7'h2B, 1'b1}, 1'b0, 1'b0, "R3");
        recv_byte(8'hFF, 8'h00, 1'b1, "R3");
        stop_c();
        check(txreq_cnt == t0, "R3", "no tx_req when unaddressed", txreq_cnt - t0, 0);

        // R5/R6: read with acks then NACK
        tx_data = 8'h96;
        t0 = txreq_cnt;
        start_c();
        send_byte({7'h2A, 1'b1}, 1'b1, 1'b0, "R2");
        recv_byte(8'h96, 8'h5A, 1'b1, "R5");
        recv_byte(8'h5A, 8'h81, 1'b1, "R5");
        recv_byte(8'h81, 8'h00, 1'b0, "R6");
        check(txreq_cnt - t0 == 3, "R5", "tx_req pulses", txreq_cnt - t0, 3);
        recv_byte(8'hFF, 8'h00, 1'b0, "R6");
        check(txreq_cnt - t0 == 3, "R6", "no request after NACK", txreq_cnt - t0, 3);
        stop_c();

        // R7: repeated START after a byte, switching to read
        tx_data = 8'hC3;
        start_c();
        send_byte({7'h2A, 1'b0}, 1'b1, 1'b0, "R2");
        send_byte(8'h11, 1'b1, 1'b1, "R4");
        start_c();
        send_byte({7'h2A, 1'b1}, 1'b1, 1'b0, "R7");
        recv_byte(8'hC3, 8'h00, 1'b0, "R7");
        stop_c();

        // R7: repeated START in the middle of a byte
        start_c();
        send_byte({7'h2A, 1'b0}, 1'b1, 1'b0, "R2");
        bus_bit(1'b1, s);
        bus_bit(1'b0, s);
        bus_bit(1'b1, s);
        start_c();
        send_byte({7'h2A, 1'b0}, 1'b1, 1'b0, "R7");
        send_byte(8'h77, 1'b1, 1'b1, "R7");
        stop_c();
        tick(4);
        check(exp_rx.size() == 0, "R7", "only the byte after restart", exp_rx.size(), 0);

        // R8: STOP directly after the address acknowledge
        start_c();
        send_byte({7'h2A, 1'b0}, 1'b1, 1'b0, "R2");
        stop_c();
        tick(4);
        check(sda_oe == 1'b0, "R8", "released after early STOP", int'(sda_oe), 0);
        scl_m = 1'b0;
        tick(5);
        send_byte({7'h2A, 1'b0}, 1'b0, 1'b0, "R8");
        send_byte(8'h44, 1'b0, 1'b0, "R8");
        stop_c();

        // R2/R3: changed own address
        own_addr = 7'h7F;
        tick(4);
        start_c();
        send_byte({7'h7F, 1'b0}, 1'b1, 1'b0, "R2");
        send_byte(8'h01, 1'b1, 1'b1, "R4");
        stop_c();
        start_c();
        send_byte({7'h7E, 1'b0}, 1'b0, 1'b0, "R3");
        send_byte(8'h02, 1'b0, 1'b0, "R3");
        stop_c();
        tick(10);
        check(exp_rx.size() == 0, "R4", "queue drained at end", exp_rx.size(), 0);

        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

endmodule